// File: doc/BRIEF.md
# Explicit-Effect Execute Datapath

This block is the execute half of a two-stage processor whose instruction word spells out, field by field, what every part of the datapath does in one cycle. Fetch presents a word together with the PC it was fetched from. During the following cycle the block carries out every effect in that word at once. These effects include general register reads, one ALU operation, one memory access, a sign extension, a sequential-address capture, a copy, a general register write, a branch and the capture of a floating-point result. All results commit together at the next rising edge.

The block has no pipeline latches, no forwarding paths and no hazard checks. In their place is a bank of ten internal registers that software names directly and that keep their contents until an effect overwrites them. Indexes 0 to 9 hold, in order: rs_a, rs_b, load value, sequential address, immediate, ALU result, branch target, FP result, copy A and copy B. A taken branch raises a redirect to fetch during the same cycle, with a target taken from one of these registers. The general register file (16 x 32) sits inside the block. The internal and general register contents are brought out as flat observation vectors, so the bench can compare every register on every cycle.

Top module: `spx_effect_core`

## Requirements
- R1: The instruction word is 61 bits. From MSB to LSB its fields are: rda_en, rda_addr[4], rdb_en, rdb_addr[4], alu_op[4], alu_a[4], alu_b[4], mem_op[2], mem_src[4], se_en, imm[8], seq_en, cp_op[2], cp_src[4], wr_en, wr_addr[4], wr_src[4], br_op[3], br_src[4] and fp_ld. All effects commit together at the rising edge that ends the cycle. Every read inside an instruction sees the values from before that instruction, so there is no forwarding between the effects of one word.
- R2: When rda_en is set, internal register 0 is loaded from general register rda_addr. When rdb_en is set, internal register 1 is loaded from general register rdb_addr.
- R3: Reset clears all ten internal registers and all general registers to zero. An internal register changes only on a cycle in which its own effect is enabled.
- R4: mem_op 1 is a load and mem_op 2 is a store; codes 0 and 3 do nothing. A load or store raises mem_req, and a store also raises mem_we. The address is the value of source mem_src and the store data is internal register 1. A load writes mem_rdata into internal register 2.
- R5: When seq_en is set, internal register 3 receives pc + 4.
- R6: When se_en is set, internal register 4 receives imm sign-extended to 32 bits.
- R7: alu_op codes are 1 add, 2 sub, 3 and, 4 or, 5 xor, 6 signed set-less-than, 7 shift left and 8 logical shift right. Shifts use the low 5 bits of b. Codes 0 and 9 to 15 do nothing. The operands are sources alu_a and alu_b. If either operand code is 10 (the PC), the result goes to register 6; otherwise it goes to register 5.
- R8: Source codes 0 to 9 select the internal register with that index, code 10 selects pc, and codes 11 to 15 read as zero. cp_op 1 copies source cp_src into register 8, cp_op 2 copies it into register 9, and codes 0 and 3 do nothing.
- R9: When wr_en is set, general register wr_addr receives source wr_src.
- R10: br_op 1 is always taken. br_op 2 is taken when register 0 is zero, br_op 3 when register 0 is non-zero, and br_op 4 when register 5 is non-zero. Codes 0 and 5 to 7 are never taken. A taken branch raises redirect_valid in the same cycle, with redirect_pc equal to source br_src.
- R11: When fp_ld is set, internal register 7 receives fp_result.
- R12: An all-zero word raises neither mem_req, nor a register file write, nor redirect_valid, and leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 61 | Effect word executed this cycle |
| pc | input | 32 | Address that instr was fetched from |
| fp_result | input | 32 | Result offered by the floating-point unit |
| mem_rdata | input | 32 | Load data, valid in the same cycle |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a store |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Store data |
| redirect_valid | output | 1 | Taken branch, one cycle |
| redirect_pc | output | 32 | Branch target |
| ireg_view | output | 320 | Internal registers, index i at bits [32i+31:32i] |
| gpr_view | output | 512 | General registers, index i at bits [32i+31:32i] |

## Verification
The hardest case to reach is a word that reads a register while another effect of the same word writes it. The bench builds this directly: it writes a general register and replaces the immediate in one word, and it writes a general register from the ALU result while computing a new ALU result. In both cases it checks that the old value lands. A counted loop is driven by following the block's own redirect to choose the next PC. It exercises reuse of the sequential address as the target, together with decrement-and-test. A long stretch of pseudo-random words then hits field combinations and reserved codes that no directed sequence names.

// File: rtl/spx_effect_pkg.sv
package spx_effect_pkg;
  localparam int XLEN    = 32;
  localparam int NIREG   = 10;
  localparam int SEL_W   = 4;
  localparam int NSRC    = 2 ** SEL_W;
  localparam int GPR_AW  = 4;
  localparam int NGPR    = 2 ** GPR_AW;
  localparam int IMM_W   = 8;
  localparam int SH_W    = $clog2(XLEN);
  localparam int PC_STEP = 4;

  localparam int IX_RSA  = 0;
  localparam int IX_RSB  = 1;
  localparam int IX_LDV  = 2;
  localparam int IX_SEQ  = 3;
  localparam int IX_IMM  = 4;
  localparam int IX_ALU  = 5;
  localparam int IX_TGT  = 6;
  localparam int IX_FPR  = 7;
  localparam int IX_CPA  = 8;
  localparam int IX_CPB  = 9;
  localparam logic [SEL_W-1:0] SRC_PC = 4'd10;

  localparam logic [3:0] ALU_ADD = 4'd1;
  localparam logic [3:0] ALU_SUB = 4'd2;
  localparam logic [3:0] ALU_AND = 4'd3;
  localparam logic [3:0] ALU_OR  = 4'd4;
  localparam logic [3:0] ALU_XOR = 4'd5;
  localparam logic [3:0] ALU_SLT = 4'd6;
  localparam logic [3:0] ALU_SLL = 4'd7;
  localparam logic [3:0] ALU_SRL = 4'd8;

  localparam logic [1:0] MEM_LOAD  = 2'd1;
  localparam logic [1:0] MEM_STORE = 2'd2;
  localparam logic [1:0] CP_TO_A   = 2'd1;
  localparam logic [1:0] CP_TO_B   = 2'd2;

  localparam logic [2:0] BR_ALWAYS = 3'd1;
  localparam logic [2:0] BR_RSA_Z  = 3'd2;
  localparam logic [2:0] BR_RSA_NZ = 3'd3;
  localparam logic [2:0] BR_ALU_NZ = 3'd4;

  typedef struct packed {
    logic              rda_en;
    logic [GPR_AW-1:0] rda_addr;
    logic              rdb_en;
    logic [GPR_AW-1:0] rdb_addr;
    logic [3:0]        alu_op;
    logic [SEL_W-1:0]  alu_a;
    logic [SEL_W-1:0]  alu_b;
    logic [1:0]        mem_op;
    logic [SEL_W-1:0]  mem_src;
    logic              se_en;
    logic [IMM_W-1:0]  imm;
    logic              seq_en;
    logic [1:0]        cp_op;
    logic [SEL_W-1:0]  cp_src;
    logic              wr_en;
    logic [GPR_AW-1:0] wr_addr;
    logic [SEL_W-1:0]  wr_src;
    logic [2:0]        br_op;
    logic [SEL_W-1:0]  br_src;
    logic              fp_ld;
  } effect_word_t;

  localparam int IW = $bits(effect_word_t);

  function automatic logic alu_code_live(input logic [3:0] op);
    return (op != 4'd0) && (op <= ALU_SRL);
  endfunction

  function automatic logic [XLEN-1:0] alu_calc(input logic [3:0] op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [SH_W-1:0] sh;
    sh = b[SH_W-1:0];
    case (op)
      ALU_ADD: return a + b;
      ALU_SUB: return a - b;
      ALU_AND: return a & b;
      ALU_OR:  return a | b;
      ALU_XOR: return a ^ b;
      ALU_SLT: return {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLL: return a << sh;
      ALU_SRL: return a >> sh;
      default: return '0;
    endcase
  endfunction

  function automatic logic branch_taken(input logic [2:0] op,
                                        input logic [XLEN-1:0] rsa,
                                        input logic [XLEN-1:0] alur);
    case (op)
      BR_ALWAYS: return 1'b1;
      BR_RSA_Z:  return rsa == '0;
      BR_RSA_NZ: return rsa != '0;
      BR_ALU_NZ: return alur != '0;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
  endfunction
endpackage

// File: rtl/spx_effect_decode.sv
module spx_effect_decode
  import spx_effect_pkg::*;
(
  input  logic             rda_en,
  input  logic             rdb_en,
  input  logic [3:0]       alu_op,
  input  logic [SEL_W-1:0] alu_a,
  input  logic [SEL_W-1:0] alu_b,
  input  logic [1:0]       mem_op,
  input  logic             se_en,
  input  logic             seq_en,
  input  logic [1:0]       cp_op,
  input  logic             fp_ld,
  output logic [NIREG-1:0] ireg_we,
  output logic             mem_req,
  output logic             mem_we,
  output logic             alu_to_tgt
);
  logic alu_live;
  logic is_load;

  assign alu_live   = alu_code_live(alu_op);
  assign alu_to_tgt = (alu_a == SRC_PC) || (alu_b == SRC_PC);
  assign is_load    = (mem_op == MEM_LOAD);
  assign mem_we     = (mem_op == MEM_STORE);
  assign mem_req    = is_load || mem_we;

  always_comb begin
    ireg_we         = '0;
    ireg_we[IX_RSA] = rda_en;
    ireg_we[IX_RSB] = rdb_en;
    ireg_we[IX_LDV] = is_load;
    ireg_we[IX_SEQ] = seq_en;
    ireg_we[IX_IMM] = se_en;
    ireg_we[IX_ALU] = alu_live && !alu_to_tgt;
    ireg_we[IX_TGT] = alu_live && alu_to_tgt;
    ireg_we[IX_FPR] = fp_ld;
    ireg_we[IX_CPA] = (cp_op == CP_TO_A);
    ireg_we[IX_CPB] = (cp_op == CP_TO_B);
  end
endmodule

// File: rtl/spx_ireg_bank.sv
module spx_ireg_bank #(
  parameter int W = 32,
  parameter int N = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        we,
  input  logic [N-1:0][W-1:0] d,
  output logic [N-1:0][W-1:0] q
);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)     q[i] <= '0;
      else if (we[i]) q[i] <= d[i];
    end

    // R3: a register with no effect this cycle keeps its value
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(we[i])) |-> $stable(q[i]));
  end
endmodule

// File: rtl/spx_gpr_bank.sv
module spx_gpr_bank #(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            ra_a,
  input  logic [AW-1:0]            ra_b,
  output logic [W-1:0]             rd_a,
  output logic [W-1:0]             rd_b,
  input  logic                     we,
  input  logic [AW-1:0]            wa,
  input  logic [W-1:0]             wd,
  output logic [(2**AW)-1:0][W-1:0] view
);
  localparam int NR = 2 ** AW;
  logic [NR-1:0][W-1:0] regs;
  logic past_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)  past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  for (genvar i = 0; i < NR; i++) begin : g_gpr
    always_ff @(posedge clk) begin
      if (!rst_n)                         regs[i] <= '0;
      else if (we && (wa == AW'(i)))      regs[i] <= wd;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];
  assign view = regs;

  // R9: the addressed register holds the written data after the edge
  assert_rf_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(we)) |-> (regs[$past(wa)] == $past(wd)));
endmodule

// File: rtl/spx_effect_core.sv
module spx_effect_core
  import spx_effect_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IW-1:0]         instr,
  input  logic [XLEN-1:0]       pc,
  input  logic [XLEN-1:0]       fp_result,
  input  logic [XLEN-1:0]       mem_rdata,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [XLEN-1:0]       mem_addr,
  output logic [XLEN-1:0]       mem_wdata,
  output logic                  redirect_valid,
  output logic [XLEN-1:0]       redirect_pc,
  output logic [NIREG*XLEN-1:0] ireg_view,
  output logic [NGPR*XLEN-1:0]  gpr_view
);
  effect_word_t ew;
  assign ew = effect_word_t'(instr);

  logic [NIREG-1:0]           ireg_we;
  logic [NIREG-1:0][XLEN-1:0] ireg_d;
  logic [NIREG-1:0][XLEN-1:0] ireg_q;
  logic [NSRC-1:0][XLEN-1:0]  src_val;
  logic [NGPR-1:0][XLEN-1:0]  gpr_q;
  logic [XLEN-1:0]            gpr_rda, gpr_rdb, alu_res;
  logic                       alu_to_tgt;
  logic                       past_ok;

  spx_effect_decode i_dec (
    .rda_en (ew.rda_en), .rdb_en (ew.rdb_en),
    .alu_op (ew.alu_op), .alu_a (ew.alu_a), .alu_b (ew.alu_b),
    .mem_op (ew.mem_op), .se_en (ew.se_en), .seq_en (ew.seq_en),
    .cp_op (ew.cp_op), .fp_ld (ew.fp_ld),
    .ireg_we (ireg_we), .mem_req (mem_req), .mem_we (mem_we),
    .alu_to_tgt (alu_to_tgt)
  );

  always_comb begin
    src_val = '0;
    for (int k = 0; k < NIREG; k++) src_val[k] = ireg_q[k];
    src_val[SRC_PC] = pc;
  end

  assign alu_res = alu_calc(ew.alu_op, src_val[ew.alu_a], src_val[ew.alu_b]);

  always_comb begin
    ireg_d         = '0;
    ireg_d[IX_RSA] = gpr_rda;
    ireg_d[IX_RSB] = gpr_rdb;
    ireg_d[IX_LDV] = mem_rdata;
    ireg_d[IX_SEQ] = pc + XLEN'(PC_STEP);
    ireg_d[IX_IMM] = sext_imm(ew.imm);
    ireg_d[IX_ALU] = alu_res;
    ireg_d[IX_TGT] = alu_res;
    ireg_d[IX_FPR] = fp_result;
    ireg_d[IX_CPA] = src_val[ew.cp_src];
    ireg_d[IX_CPB] = src_val[ew.cp_src];
  end

  spx_ireg_bank #(.W(XLEN), .N(NIREG)) i_ireg (
    .clk (clk), .rst_n (rst_n), .we (ireg_we), .d (ireg_d), .q (ireg_q)
  );

  spx_gpr_bank #(.W(XLEN), .AW(GPR_AW)) i_gpr (
    .clk (clk), .rst_n (rst_n),
    .ra_a (ew.rda_addr), .ra_b (ew.rdb_addr),
    .rd_a (gpr_rda), .rd_b (gpr_rdb),
    .we (ew.wr_en), .wa (ew.wr_addr), .wd (src_val[ew.wr_src]),
    .view (gpr_q)
  );

  assign mem_addr       = src_val[ew.mem_src];
  assign mem_wdata      = ireg_q[IX_RSB];
  assign redirect_valid = branch_taken(ew.br_op, ireg_q[IX_RSA], ireg_q[IX_ALU]);
  assign redirect_pc    = src_val[ew.br_src];
  assign ireg_view      = ireg_q;
  assign gpr_view       = gpr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R12: an all-zero word touches neither memory, register file nor fetch
  assert_nop_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (instr == '0) |-> (!mem_req && !ew.wr_en && !redirect_valid));

  assert_store_has_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  assert_load_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(mem_req && !mem_we)) |-> (ireg_q[IX_LDV] == $past(mem_rdata)));

  assert_seq_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(ew.seq_en)) |-> (ireg_q[IX_SEQ] == $past(pc) + XLEN'(PC_STEP)));

  assert_one_alu_dest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ireg_we[IX_ALU], ireg_we[IX_TGT]}) <= 1);

  assert_redirect_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (ew.br_op != 3'd0));

  assert_fp_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(ew.fp_ld)) |-> (ireg_q[IX_FPR] == $past(fp_result)));
endmodule

// File: tb/test_spx_effect_core.sv
`timescale 1ns/1ps
module test_spx_effect_core;
  import spx_effect_pkg::*;

  localparam real CLK_NS = 20.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IW-1:0] instr = '0;
  logic [31:0] pc = '0, fp_result = '0, mem_rdata;
  logic mem_req, mem_we, redirect_valid;
  logic [31:0] mem_addr, mem_wdata, redirect_pc;
  logic [NIREG*32-1:0] ireg_view;
  logic [NGPR*32-1:0]  gpr_view;

  always #(CLK_NS/2) clk = ~clk;

  spx_effect_core i_spx_effect_core (
    .clk (clk), .rst_n (rst_n), .instr (instr), .pc (pc),
    .fp_result (fp_result), .mem_rdata (mem_rdata),
    .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
    .mem_wdata (mem_wdata), .redirect_valid (redirect_valid),
    .redirect_pc (redirect_pc), .ireg_view (ireg_view), .gpr_view (gpr_view)
  );

  logic [31:0] bmem [64];
  assign mem_rdata = bmem[mem_addr[7:2]];
  always @(posedge clk) if (mem_req && mem_we) bmem[mem_addr[7:2]] <= mem_wdata;

  int vecs = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_ir [10];
  logic [31:0] m_gp [16];
  logic [31:0] cur_pc = 32'h100;
  logic [31:0] lcg = 32'h1357_9bdf;
  bit last_taken;
  bit s_req, s_redir;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string reg_req(input int i);
    case (i)
      0, 1: return "R2";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5, 6: return "R7";
      7: return "R11";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [31:0] ref_src(input logic [3:0] s);
    if (s < 4'd10) return m_ir[s];
    if (s == 4'd10) return cur_pc;
    return 32'd0;
  endfunction

  function automatic logic [31:0] ref_alu(input logic [3:0] op,
                                          input logic [31:0] a, input logic [31:0] b);
    int sa, sb;
    sa = a; sb = b;
    case (op)
      1: return a + b;
      2: return a - b;
      3: return a & b;
      4: return a | b;
      5: return a ^ b;
      6: return (sa < sb) ? 32'd1 : 32'd0;
      7: return a << b[4:0];
      8: return a >> b[4:0];
      default: return 32'd0;
    endcase
  endfunction

  task automatic compare_views();
    for (int i = 0; i < 10; i++)
      chk(reg_req(i), $sformatf("ireg%0d", i), ireg_view[i*32 +: 32], m_ir[i]);
    for (int i = 0; i < 16; i++)
      chk("R9", $sformatf("gpr%0d", i), gpr_view[i*32 +: 32], m_gp[i]);
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input effect_word_t w, input logic [31:0] fres);
    logic [31:0] n_ir [10];
    logic [31:0] n_gp [16];
    logic [31:0] res, tgt;
    bit ld, st, tk;
    instr = w; pc = cur_pc; fp_result = fres;
    #1;
    ld = (w.mem_op == 2'd1);
    st = (w.mem_op == 2'd2);
    case (w.br_op)
      3'd1: tk = 1;
      3'd2: tk = (m_ir[0] == 0);
      3'd3: tk = (m_ir[0] != 0);
      3'd4: tk = (m_ir[5] != 0);
      default: tk = 0;
    endcase
    tgt = ref_src(w.br_src);
    s_req = mem_req; s_redir = redirect_valid;
    chk("R4", "mem_req", {31'd0, mem_req}, {31'd0, ld || st});
    chk("R4", "mem_we", {31'd0, mem_we}, {31'd0, st});
    if (ld || st) chk("R4", "mem_addr", mem_addr, ref_src(w.mem_src));
    if (st) chk("R4", "mem_wdata", mem_wdata, m_ir[1]);
    chk("R10", "redirect_valid", {31'd0, redirect_valid}, {31'd0, tk});
    if (tk) chk("R10", "redirect_pc", redirect_pc, tgt);
    n_ir = m_ir; n_gp = m_gp;
    if (w.rda_en) n_ir[0] = m_gp[w.rda_addr];
    if (w.rdb_en) n_ir[1] = m_gp[w.rdb_addr];
    if (w.alu_op >= 4'd1 && w.alu_op <= 4'd8) begin
      res = ref_alu(w.alu_op, ref_src(w.alu_a), ref_src(w.alu_b));
      if (w.alu_a == 4'd10 || w.alu_b == 4'd10) n_ir[6] = res;
      else n_ir[5] = res;
    end
    if (ld) n_ir[2] = bmem[ref_src(w.mem_src)][7:2] == 0 ? bmem[ref_src(w.mem_src) >> 2 & 32'h3f] : bmem[ref_src(w.mem_src) >> 2 & 32'h3f];
    if (w.seq_en) n_ir[3] = cur_pc + 32'd4;
    if (w.se_en) n_ir[4] = {{24{w.imm[7]}}, w.imm};
    if (w.fp_ld) n_ir[7] = fres;
    if (w.cp_op == 2'd1) n_ir[8] = ref_src(w.cp_src);
    if (w.cp_op == 2'd2) n_ir[9] = ref_src(w.cp_src);
    if (w.wr_en) n_gp[w.wr_addr] = ref_src(w.wr_src);
    last_taken = tk;
    @(negedge clk);
    m_ir = n_ir; m_gp = n_gp;
    cur_pc = tk ? tgt : cur_pc + 32'd4;
    compare_views();
  endtask

  function automatic logic [31:0] rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog run did not finish actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    effect_word_t w;
    logic [NIREG*32-1:0] snap_i;
    logic [NGPR*32-1:0]  snap_g;
    int iters;
    for (int i = 0; i < 64; i++) bmem[i] = 32'hA000_0000 + i;
    for (int i = 0; i < 10; i++) m_ir[i] = '0;
    for (int i = 0; i < 16; i++) m_gp[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3: reset state of every register
    for (int i = 0; i < 10; i++) chk("R3", "reset ireg", ireg_view[i*32 +: 32], 32'd0);
    for (int i = 0; i < 16; i++) chk("R3", "reset gpr", gpr_view[i*32 +: 32], 32'd0);

    // add sequence
    w = '0; w.se_en = 1; w.imm = 8'd5; w.fp_ld = 1; step(w, 32'h1234_5678);
    // R1: gpr1 takes the old immediate while a new one is captured
    w = '0; w.wr_en = 1; w.wr_addr = 4'd1; w.wr_src = 4'd4; w.se_en = 1; w.imm = 8'hFD;
    step(w, 32'd0);
    chk("R1", "gpr1 sees pre-instruction imm", gpr_view[32 +: 32], 32'd5);
    w = '0; w.wr_en = 1; w.wr_addr = 4'd2; w.wr_src = 4'd4; w.rda_en = 1; w.rda_addr = 4'd1;
    step(w, 32'd0);
    w = '0; w.rdb_en = 1; w.rdb_addr = 4'd2; step(w, 32'd0);
    w = '0; w.alu_op = 4'd1; w.alu_a = 4'd0; w.alu_b = 4'd1;
    w.wr_en = 1; w.wr_addr = 4'd3; w.wr_src = 4'd5; step(w, 32'd0);
    chk("R1", "gpr3 got old ALU result", gpr_view[96 +: 32], 32'd0);
    chk("R7", "add 5 + -3", ireg_view[160 +: 32], 32'd2);
    w = '0; w.wr_en = 1; w.wr_addr = 4'd3; w.wr_src = 4'd5; w.cp_op = 2'd1; w.cp_src = 4'd5;
    w.seq_en = 1; step(w, 32'd0);
    for (int op = 2; op <= 9; op++) begin
      w = '0; w.alu_op = 4'(op); w.alu_a = 4'd0; w.alu_b = 4'd1;
      w.cp_op = 2'd2; w.cp_src = 4'd7; step(w, 32'd0);
    end
    w = '0; w.alu_op = 4'd1; w.alu_a = 4'd10; w.alu_b = 4'd4; step(w, 32'd0);

    // load-use sequence
    w = '0; w.se_en = 1; w.imm = 8'd16; step(w, 32'd0);
    w = '0; w.mem_op = 2'd2; w.mem_src = 4'd4; step(w, 32'd0);
    w = '0; w.mem_op = 2'd1; w.mem_src = 4'd4; step(w, 32'd0);
    chk("R4", "load returns stored value", ireg_view[64 +: 32], 32'hFFFF_FFFD);
    w = '0; w.alu_op = 4'd1; w.alu_a = 4'd2; w.alu_b = 4'd0;
    w.wr_en = 1; w.wr_addr = 4'd4; w.wr_src = 4'd2; step(w, 32'd0);
    w = '0; w.mem_op = 2'd3; step(w, 32'd0);

    // loop: r5 = 3, decrement until zero, branch back to saved sequential address
    w = '0; w.se_en = 1; w.imm = 8'd3; step(w, 32'd0);
    w = '0; w.wr_en = 1; w.wr_addr = 4'd5; w.wr_src = 4'd4; w.se_en = 1; w.imm = 8'd1;
    step(w, 32'd0);
    w = '0; w.seq_en = 1; step(w, 32'd0);
    iters = 0;
    for (int it = 0; it < 8; it++) begin
      iters++;
      w = '0; w.rda_en = 1; w.rda_addr = 4'd5; step(w, 32'd0);
      w = '0; w.alu_op = 4'd2; w.alu_a = 4'd0; w.alu_b = 4'd4; step(w, 32'd0);
      w = '0; w.wr_en = 1; w.wr_addr = 4'd5; w.wr_src = 4'd5; w.br_op = 3'd4; w.br_src = 4'd3;
      step(w, 32'd0);
      if (!last_taken) break;
    end
    chk("R10", "loop iterations", iters, 32'd3);
    w = '0; w.alu_op = 4'd1; w.alu_a = 4'd10; w.alu_b = 4'd11; step(w, 32'd0);
    w = '0; w.br_op = 3'd1; w.br_src = 4'd6; step(w, 32'd0);
    w = '0; w.br_op = 3'd2; w.br_src = 4'd8; step(w, 32'd0);
    w = '0; w.br_op = 3'd3; w.br_src = 4'd8; step(w, 32'd0);
    w = '0; w.br_op = 3'd6; w.br_src = 4'd8; step(w, 32'd0);

    // R12: all-zero word leaves everything alone
    snap_i = ireg_view; snap_g = gpr_view;
    step('0, 32'hDEAD_BEEF);
    chk("R12", "nop mem_req", {31'd0, s_req}, 32'd0);
    chk("R12", "nop redirect", {31'd0, s_redir}, 32'd0);
    for (int i = 0; i < 10; i++) chk("R12", "nop ireg", ireg_view[i*32 +: 32], snap_i[i*32 +: 32]);
    for (int i = 0; i < 16; i++) chk("R12", "nop gpr", gpr_view[i*32 +: 32], snap_g[i*32 +: 32]);

    // pseudo-random effect words
    for (int n = 0; n < 300; n++) begin
      logic [63:0] r;
      r = {rnd(), rnd()};
      step(effect_word_t'(r[IW-1:0]), rnd());
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule